// File: doc/BRIEF.md
# Integer ALU with Condition-Code Register

This block carries out one of four integer operations on two 32-bit operands and keeps a three-bit condition-code register for the branch logic around it. A 4-bit function code picks the operation: add, subtract, bitwise AND or bitwise XOR. Operand A comes from the first-named register of the instruction and operand B from the second-named one. Subtraction forms B minus A, because the result is written back over B. The result is combinational and is valid in the same cycle as the operands.

The condition codes are zero, sign and two's-complement overflow. They are loaded on a rising clock edge only when the set_cc enable is high and the function code is one of the four defined values. Moves, jumps and every other instruction drive set_cc low, so the flags they see are those of the last arithmetic or logical instruction. A synchronous reset puts the register in the state zero set, sign clear, overflow clear.

The flag register is the only state in the block. Its two conditions are "load" (set_cc high and a defined code) and "hold" (any other cycle). A synchronous reset takes priority over both.

Top module: `alu_ccr`

## Requirements
- R1: Function code 0 drives `result` with opnd_a + opnd_b modulo 2^32, in the same cycle.
- R2: Function code 1 drives `result` with opnd_b - opnd_a modulo 2^32, so B is the minuend.
- R3: Function code 2 drives `result` with the bitwise AND of the operands, and code 3 drives it with their bitwise XOR.
- R4: On a rising edge with set_cc high and a defined code, `cc_out[2]` (zero) loads 1 exactly when the result is all zeros, and `cc_out[1]` (sign) loads bit 31 of the result.
- R5: For code 0, `cc_out[0]` (overflow) loads 1 when the two operands share a sign bit and the sign bit of the sum differs from it.
- R6: For code 1, `cc_out[0]` loads 1 when the sign bits of B and A differ and the sign bit of the difference differs from that of B.
- R7: For codes 2 and 3, `cc_out[0]` loads 0.
- R8: While set_cc is low, `cc_out` keeps its value across clock edges whatever the function code and operands are.
- R9: For a function code from 4 to 15, `result` is 0 and `cc_out` keeps its value even when set_cc is high.
- R10: A rising edge with rst high sets `cc_out` to 3'b100 (zero 1, sign 0, overflow 0), and this takes priority over set_cc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| func_code | input | 4 | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_a | input | 32 | Operand A, taken from the first-named register |
| opnd_b | input | 32 | Operand B, taken from the second-named register |
| set_cc | input | 1 | Load enable for the condition codes |
| result | output | 32 | Combinational operation result |
| cc_out | output | 3 | Registered flags: bit 2 zero, bit 1 sign, bit 0 overflow |

## Verification
The hard case is an instruction that must leave the flags alone: an undefined code with set_cc high, or a defined code with set_cc low. A check of that kind shows something only if the register already holds a value that the ignored operation would have changed. The bench therefore first loads a distinctive pattern such as sign-plus-overflow or zero-only from the vector table. It then applies the ignored stimulus with operands that would produce a different pattern, and compares `cc_out` against the earlier value on the next edge. Reset is checked in the same way: it is asserted together with set_cc while the flags hold a non-reset pattern.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

    typedef enum logic [3:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } cc_flags_t;

    localparam cc_flags_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_ccr_exec.sv
module alu_ccr_exec
    import alu_ccr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       func_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output cc_flags_t        flags_nxt,
    output logic             code_ok
);
    localparam int MSB = WIDTH - 1;

    alu_fn_e          fn;
    logic [WIDTH-1:0] sum_v;
    logic [WIDTH-1:0] dif_v;
    logic             ovf_add;
    logic             ovf_sub;

    assign fn    = alu_fn_e'(func_code);
    assign sum_v = opnd_a + opnd_b;
    assign dif_v = opnd_b - opnd_a;

    // same-sign inputs with a flipped sum sign
    assign ovf_add = (opnd_a[MSB] == opnd_b[MSB]) && (sum_v[MSB] != opnd_a[MSB]);
    // differing signs, difference sign departs from the minuend B
    assign ovf_sub = (opnd_a[MSB] != opnd_b[MSB]) && (dif_v[MSB] != opnd_b[MSB]);

    always_comb begin
        result  = '0;
        code_ok = 1'b1;
        flags_nxt.of = 1'b0;
        unique case (fn)
            FN_ADD: begin
                result       = sum_v;
                flags_nxt.of = ovf_add;
            end
            FN_SUB: begin
                result       = dif_v;
                flags_nxt.of = ovf_sub;
            end
            FN_AND: result = opnd_a & opnd_b;
            FN_XOR: result = opnd_a ^ opnd_b;
            default: begin
                result  = '0;
                code_ok = 1'b0;
            end
        endcase
        flags_nxt.zf = (result == '0);
        flags_nxt.sf = result[MSB];
    end

endmodule

// File: rtl/alu_ccr_flagreg.sv
module alu_ccr_flagreg
    import alu_ccr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cc_flags_t flags_nxt,
    output cc_flags_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= CC_RESET;
        end else if (load) begin
            flags_q <= flags_nxt;
        end
    end

    // R10: reset value after a reset edge
    p_reset_value_r10: assert property (@(posedge clk) rst |=> (flags_q == 3'b100));

    // R8: hold whenever no load is requested
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(flags_q));

endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
    import alu_ccr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       func_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             set_cc,
    output logic [WIDTH-1:0] result,
    output logic [2:0]       cc_out
);
    cc_flags_t flags_nxt;
    cc_flags_t flags_q;
    logic      code_ok;
    logic      load;

    alu_ccr_exec #(.WIDTH(WIDTH)) exec_i (
        .func_code (func_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .flags_nxt (flags_nxt),
        .code_ok   (code_ok)
    );

    assign load = set_cc && code_ok;

    alu_ccr_flagreg flag_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .flags_nxt (flags_nxt),
        .flags_q   (flags_q)
    );

    assign cc_out = flags_q;

    // R4: latched zero flag agrees with the result that was loaded
    p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (set_cc && func_code < 4'd4) |=> (cc_out[2] == ($past(result) == '0)));

    // R7: logic operations leave overflow clear
    p_logic_of_r7: assert property (@(posedge clk) disable iff (rst)
        (set_cc && (func_code == 4'd2 || func_code == 4'd3)) |=> !cc_out[0]);

    // R9: undefined code gives a zero result
    p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (func_code > 4'd3) |-> (result == '0));

    // R9: undefined code keeps the flags
    p_undef_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (func_code > 4'd3) |=> $stable(cc_out));

endmodule

// File: tb/alu_ccr_tb_top.sv
module alu_ccr_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  func_code;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        set_cc;
    logic [31:0] result;
    logic [2:0]  cc_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alu_ccr dut_i (
        .clk       (clk),
        .rst       (rst),
        .func_code (func_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .set_cc    (set_cc),
        .result    (result),
        .cc_out    (cc_out)
    );

    // cc encoding: {zero, sign, overflow}
    localparam int NV = 11;
    localparam logic [3:0]  V_FN  [NV] = '{4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd1,
                                           4'd2, 4'd1, 4'd3, 4'd3};
    localparam logic [31:0] V_A   [NV] = '{32'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000,
                                           32'd5, 32'd1, 32'hFFFFFFFF, 32'hF0F0F0F0,
                                           32'd7, 32'h12345678, 32'h7FFFFFFF};
    localparam logic [31:0] V_B   [NV] = '{32'd2, 32'd1, 32'd1, 32'h80000000,
                                           32'd3, 32'h80000000, 32'h7FFFFFFF, 32'h8F00FF00,
                                           32'd7, 32'h12345678, 32'hFFFFFFFF};
    localparam logic [31:0] V_RES [NV] = '{32'd3, 32'h80000000, 32'd0, 32'd0,
                                           32'hFFFFFFFE, 32'h7FFFFFFF, 32'h80000000, 32'h8000F000,
                                           32'd0, 32'd0, 32'h80000000};
    localparam logic [2:0]  V_CC  [NV] = '{3'b000, 3'b011, 3'b100, 3'b101,
                                           3'b010, 3'b001, 3'b011, 3'b010,
                                           3'b100, 3'b100, 3'b010};
    localparam string       V_TAG [NV] = '{"R1", "R5", "R5", "R5", "R2", "R6", "R6",
                                           "R7", "R2", "R3", "R3"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic s);
        func_code = f;
        opnd_a    = a;
        opnd_b    = b;
        set_cc    = s;
    endtask

    initial begin
        rst = 1'b1;
        apply(4'd0, 32'd0, 32'd0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset value", {29'd0, cc_out}, 32'h4);

        // table walk: result same cycle, flags after the next edge
        for (int i = 0; i < NV; i++) begin
            apply(V_FN[i], V_A[i], V_B[i], 1'b1);
            #1;
            check({V_TAG[i], " result"}, result, V_RES[i]);
            @(negedge clk);
            check({V_TAG[i], " R4 flags"}, {29'd0, cc_out}, {29'd0, V_CC[i]});
        end

        // load sign+overflow, then hold with set_cc low (R8)
        apply(4'd0, 32'h7FFFFFFF, 32'd1, 1'b1);
        @(negedge clk);
        check("R5 setup", {29'd0, cc_out}, 32'h3);
        apply(4'd1, 32'd4, 32'd4, 1'b0);
        #1;
        check("R2 result with set_cc low", result, 32'd0);
        @(negedge clk);
        check("R8 hold with set_cc low", {29'd0, cc_out}, 32'h3);
        apply(4'd3, 32'd9, 32'd9, 1'b0);
        @(negedge clk);
        check("R8 hold second edge", {29'd0, cc_out}, 32'h3);

        // undefined codes with set_cc high (R9)
        apply(4'd4, 32'd0, 32'd0, 1'b1);
        #1;
        check("R9 result code 4", result, 32'd0);
        @(negedge clk);
        check("R9 flags code 4", {29'd0, cc_out}, 32'h3);
        apply(4'd15, 32'h80000000, 32'h12345678, 1'b1);
        #1;
        check("R9 result code 15", result, 32'd0);
        @(negedge clk);
        check("R9 flags code 15", {29'd0, cc_out}, 32'h3);

        // reset beats set_cc (R10)
        apply(4'd0, 32'h7FFFFFFF, 32'd1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset over set_cc", {29'd0, cc_out}, 32'h4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule